// File: doc/BRIEF.md
# DDR3 Mode-Register Command Generator

This block walks the ranks of a DDR3 memory channel and emits the mode-register write commands that place one chosen DIMM into write-leveling mode, or that return the channel to its normal termination settings. A single start strobe picks the target DIMM and selects leveling or normal mode. The block then issues two writes per rank. The first goes to the register that holds nominal termination, drive strength, TDQS and the leveling controls. The second goes to the register that holds write-side termination and the write-latency fields. Every command waits for an accept handshake before the next one is presented.

The target DIMM is programmed first, whether or not its presence bit is set. Every other present DIMM follows, in ascending index order, with its non-target settings. Termination strength depends on several inputs: the rank's role (target or not), the mode, the number of DIMMs per channel, the rank position inside a dual-rank DIMM, and a clock-frequency code. When a command goes to an odd chip select and address mirroring is enabled, the block swaps the mirrored address pairs and the two low bank bits before presenting the command.

Top module: `mrgen_top`

## Requirements
- R1: The chip select is `{dimm, rank}`, which equals dimm*2+rank. Rank 1 is visited only for a DIMM whose dual-rank flag is set. At most two ranks are visited per DIMM.
- R2: Each rank receives two writes in a fixed order: first bank 1 (MR1), then bank 2 (MR2). The bank values given here are before any mirroring.
- R3: The target DIMM is programmed first. Every other DIMM whose presence bit is set follows, in ascending index order. Absent non-target DIMMs are skipped.
- R4: Mirroring applies when mirroring is enabled and the chip select is odd. It swaps address bits 3↔4, 5↔6 and 7↔8, and swaps bank bits 0↔1.
- R5: MR1 bit 11 is set when TDQS is enabled and the DIMM's x8 flag is set. Drive-impedance input bit 1 sets address bit 5, and input bit 0 sets address bit 1.
- R6: This rule covers MR1 nominal termination for the target DIMM in leveling mode. The codes are 0x004 for RZQ/4, 0x040 for RZQ/2, 0x044 for RZQ/6, 0x204 for RZQ/8, and 0 for off. With one DIMM per channel, rank 0 of a dual-rank DIMM uses off and every other rank uses 0x004. With more DIMMs per channel, rank 1 of a dual-rank DIMM uses off; every other rank uses 0x004 at frequency code 6 and 0x040 at any other code.
- R7: In normal mode, MR1 nominal termination is 0x004 with 1 or 4 DIMMs per channel. Otherwise it is 0x044 when the frequency code is below 5, and 0x204 when the code is 5 or above. A non-target DIMM in leveling mode uses off on rank 1 of a dual-rank DIMM, and the same 0x044/0x204 rule on every other rank.
- R8: In leveling mode, the target DIMM's MR1 sets bit 7 (leveling enable) on every rank and sets bit 12 (output off) on rank 1. Both bits are clear on non-target DIMMs and in normal mode.
- R9: MR2 carries the self-refresh temperature bit in address bit 7, the auto-self-refresh bit in address bit 6, and the 3-bit write latency in bits 5:3. Write termination is 0 in leveling mode or with one DIMM per channel. Otherwise it is 0x200 at frequency code 6 and 0x400 at any other code.
- R10: While the accept input is low, the presented command holds stable and valid. An accept while no command is valid has no effect.
- R11: The busy output rises on the cycle after an accepted start and stays high until the last command is accepted. The done output is a single-cycle pulse in the cycle after that final accept, with busy already low.
- R12: A start strobe that arrives while busy is ignored. The running sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start strobe, accepted only while idle |
| levelMode | input | 1 | 1 selects leveling mode, 0 selects normal mode; latched at start |
| targetDimm | input | 2 | Index of the target DIMM; latched at start |
| dimmPresent | input | 4 | Presence flag for each DIMM |
| dimmDual | input | 4 | Dual-rank flag for each DIMM |
| dimmX8 | input | 4 | x8 device-width flag for each DIMM |
| tdqsEn | input | 1 | Enables the TDQS bit for x8 DIMMs |
| dimmsPerChan | input | 3 | Number of DIMMs per channel (1 to 4) |
| freqCode | input | 3 | Memory clock frequency code |
| drvImp | input | 2 | Output drive-impedance select |
| srtEn | input | 1 | Self-refresh temperature bit for MR2 |
| asrEn | input | 1 | Auto-self-refresh bit for MR2 |
| cwlCode | input | 3 | Write-latency code for MR2 |
| mirrorEn | input | 1 | Enables address and bank mirroring on odd chip selects |
| cmdAck | input | 1 | Accept for the presented command |
| cmdValid | output | 1 | A command is presented |
| cmdCs | output | 3 | Chip select of the command |
| cmdBank | output | 3 | Bank address, after any mirroring |
| cmdAddr | output | 16 | Mode-register value, after any mirroring |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse after the final accept |

## Verification
The hardest case to reach from the ports is a start strobe that lands in the middle of a sequence and carries a different target index, combined with a long-held accept. Only a correct design both keeps the running order and holds the presented command steady through that combination. The stimulus covers this by withholding the accept on the second command of every scenario, pulsing start with an inverted target index during the hold, and checking that the command is unchanged and that the rest of the order still follows the original target. The rarer termination corners are reached through scenario rows built for them: an absent target, a single-DIMM leveling pass, and mirrored rank-1 writes with the output-off bit set.

// File: rtl/mrgen_pkg.sv
package mrgen_pkg;

  localparam int MR_ADDR_W = 16;
  localparam int MR_BANK_W = 3;

  localparam logic [MR_ADDR_W-1:0] RTT_OFF  = 16'h0000;
  localparam logic [MR_ADDR_W-1:0] RTT_DIV4 = 16'h0004;
  localparam logic [MR_ADDR_W-1:0] RTT_DIV2 = 16'h0040;
  localparam logic [MR_ADDR_W-1:0] RTT_DIV6 = 16'h0044;
  localparam logic [MR_ADDR_W-1:0] RTT_DIV8 = 16'h0204;
  localparam logic [MR_ADDR_W-1:0] WR_DIV4  = 16'h0200;
  localparam logic [MR_ADDR_W-1:0] WR_DIV2  = 16'h0400;

  typedef struct packed {
    logic load;
    logic stepMr;
    logic stepRank;
    logic stepDimm;
    logic finish;
  } seqStrobe_t;

  function automatic logic [MR_ADDR_W-1:0] mirrorAddr(input logic [MR_ADDR_W-1:0] a);
    logic [MR_ADDR_W-1:0] b;
    b = a;
    for (int p = 3; p < 9; p += 2) begin
      b[p]   = a[p+1];
      b[p+1] = a[p];
    end
    return b;
  endfunction

endpackage

// File: rtl/mrgen_ctrl.sv
module mrgen_ctrl
  import mrgen_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       cmdAck,
  input  logic       lastMr,
  input  logic       moreRank,
  input  logic       hasNext,
  output seqStrobe_t stb,
  output logic       busy,
  output logic       done
);

  logic busyQ, doneQ;
  logic accept;

  assign accept = busyQ && cmdAck;

  always_comb begin
    stb          = '0;
    stb.load     = !busyQ && startReq;
    stb.stepMr   = accept && !lastMr;
    stb.stepRank = accept && lastMr && moreRank;
    stb.stepDimm = accept && lastMr && !moreRank && hasNext;
    stb.finish   = accept && lastMr && !moreRank && !hasNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= stb.finish;
      if (stb.load)        busyQ <= 1'b1;
      else if (stb.finish) busyQ <= 1'b0;
    end
  end

  assign busy = busyQ;
  assign done = doneQ;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R11
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R11
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !cmdAck) |=> busy); // R12

endmodule

// File: rtl/mrgen_seq.sv
module mrgen_seq
  import mrgen_pkg::*;
#(
  parameter int NUM_DIMMS = 4,
  localparam int DIMM_W = (NUM_DIMMS > 1) ? $clog2(NUM_DIMMS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqStrobe_t           stb,
  input  logic                 active,
  input  logic [DIMM_W-1:0]    startTarget,
  input  logic                 startLevel,
  input  logic [NUM_DIMMS-1:0] dimmPresent,
  input  logic [NUM_DIMMS-1:0] dimmDual,
  output logic [DIMM_W-1:0]    curDimm,
  output logic                 curRank,
  output logic                 curMr,
  output logic                 isTarget,
  output logic                 levelQ,
  output logic                 lastMr,
  output logic                 moreRank,
  output logic                 hasNext
);

  logic [DIMM_W-1:0] tgtQ, dimmQ, nextIdx;
  logic              rankQ, mrQ, inTgtQ, lvlQ;

  always_comb begin
    hasNext = 1'b0;
    nextIdx = '0;
    for (int i = NUM_DIMMS - 1; i >= 0; i--) begin
      if (dimmPresent[i] && (DIMM_W'(i) != tgtQ) &&
          (inTgtQ || (DIMM_W'(i) > dimmQ))) begin
        hasNext = 1'b1;
        nextIdx = DIMM_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tgtQ   <= '0;
      dimmQ  <= '0;
      rankQ  <= 1'b0;
      mrQ    <= 1'b0;
      inTgtQ <= 1'b0;
      lvlQ   <= 1'b0;
    end else if (stb.load) begin
      tgtQ   <= startTarget;
      dimmQ  <= startTarget;
      rankQ  <= 1'b0;
      mrQ    <= 1'b0;
      inTgtQ <= 1'b1;
      lvlQ   <= startLevel;
    end else if (stb.stepMr) begin
      mrQ <= 1'b1;
    end else if (stb.stepRank) begin
      rankQ <= 1'b1;
      mrQ   <= 1'b0;
    end else if (stb.stepDimm) begin
      dimmQ  <= nextIdx;
      rankQ  <= 1'b0;
      mrQ    <= 1'b0;
      inTgtQ <= 1'b0;
    end
  end

  assign curDimm  = dimmQ;
  assign curRank  = rankQ;
  assign curMr    = mrQ;
  assign isTarget = inTgtQ;
  assign levelQ   = lvlQ;
  assign lastMr   = mrQ;
  assign moreRank = !rankQ && dimmDual[dimmQ];

  AST_RANK1_DUAL: assert property (@(posedge clk) disable iff (!rstN)
    (active && rankQ) |-> dimmDual[dimmQ]); // R1
  AST_TARGET_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    stb.stepDimm |=> (!inTgtQ && (dimmQ != tgtQ) && dimmPresent[dimmQ])); // R3

endmodule

// File: rtl/mrgen_encode.sv
module mrgen_encode
  import mrgen_pkg::*;
#(
  parameter int NUM_DIMMS = 4,
  localparam int DIMM_W = (NUM_DIMMS > 1) ? $clog2(NUM_DIMMS) : 1
) (
  input  logic [DIMM_W-1:0]    dimm,
  input  logic                 rank,
  input  logic                 mrSel,
  input  logic                 isTarget,
  input  logic                 level,
  input  logic [NUM_DIMMS-1:0] dimmDual,
  input  logic [NUM_DIMMS-1:0] dimmX8,
  input  logic                 tdqsEn,
  input  logic [2:0]           dimmsPerChan,
  input  logic [2:0]           freqCode,
  input  logic [1:0]           drvImp,
  input  logic                 srtEn,
  input  logic                 asrEn,
  input  logic [2:0]           cwlCode,
  input  logic                 mirrorEn,
  output logic [DIMM_W:0]      cs,
  output logic [MR_BANK_W-1:0] bank,
  output logic [MR_ADDR_W-1:0] addr
);

  logic                 dual, swapIt, singleOrQuad, fastClk;
  logic [MR_ADDR_W-1:0] tierLow, rttNom, rttWr, mr1, mr2, rawAddr;
  logic [MR_BANK_W-1:0] rawBank;

  assign dual         = dimmDual[dimm];
  assign singleOrQuad = (dimmsPerChan == 3'd1) || (dimmsPerChan == 3'd4);
  assign fastClk      = (freqCode == 3'd6);
  assign tierLow      = (freqCode < 3'd5) ? RTT_DIV6 : RTT_DIV8;

  always_comb begin
    if (level && isTarget) begin
      if (dimmsPerChan == 3'd1) rttNom = (dual && !rank) ? RTT_OFF : RTT_DIV4;
      else rttNom = (dual && rank) ? RTT_OFF : (fastClk ? RTT_DIV4 : RTT_DIV2);
    end else if (level) begin
      rttNom = (dual && rank) ? RTT_OFF : tierLow;
    end else begin
      rttNom = singleOrQuad ? RTT_DIV4 : tierLow;
    end

    mr1     = rttNom;
    mr1[11] = tdqsEn && dimmX8[dimm];
    mr1[7]  = level && isTarget;
    mr1[12] = level && isTarget && rank;
    mr1[5]  = drvImp[1];
    mr1[1]  = drvImp[0];

    rttWr   = (level || dimmsPerChan == 3'd1) ? RTT_OFF : (fastClk ? WR_DIV4 : WR_DIV2);
    mr2     = rttWr;
    mr2[7]  = srtEn;
    mr2[6]  = asrEn;
    mr2[5:3] = cwlCode;
  end

  assign rawAddr = mrSel ? mr2 : mr1;
  assign rawBank = mrSel ? 3'd2 : 3'd1;
  assign swapIt  = mirrorEn && rank;
  assign cs      = {dimm, rank};
  assign addr    = swapIt ? mirrorAddr(rawAddr) : rawAddr;
  assign bank    = swapIt ? {rawBank[2], rawBank[0], rawBank[1]} : rawBank;

endmodule

// File: rtl/mrgen_top.sv
module mrgen_top
  import mrgen_pkg::*;
#(
  parameter int NUM_DIMMS = 4,
  localparam int DIMM_W = (NUM_DIMMS > 1) ? $clog2(NUM_DIMMS) : 1,
  localparam int CS_W = DIMM_W + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startReq,
  input  logic                 levelMode,
  input  logic [DIMM_W-1:0]    targetDimm,
  input  logic [NUM_DIMMS-1:0] dimmPresent,
  input  logic [NUM_DIMMS-1:0] dimmDual,
  input  logic [NUM_DIMMS-1:0] dimmX8,
  input  logic                 tdqsEn,
  input  logic [2:0]           dimmsPerChan,
  input  logic [2:0]           freqCode,
  input  logic [1:0]           drvImp,
  input  logic                 srtEn,
  input  logic                 asrEn,
  input  logic [2:0]           cwlCode,
  input  logic                 mirrorEn,
  input  logic                 cmdAck,
  output logic                 cmdValid,
  output logic [CS_W-1:0]      cmdCs,
  output logic [MR_BANK_W-1:0] cmdBank,
  output logic [MR_ADDR_W-1:0] cmdAddr,
  output logic                 busy,
  output logic                 done
);

  seqStrobe_t        stb;
  logic              lastMr, moreRank, hasNext;
  logic [DIMM_W-1:0] curDimm;
  logic              curRank, curMr, isTarget, levelQ;

  mrgen_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .cmdAck(cmdAck),
    .lastMr(lastMr), .moreRank(moreRank), .hasNext(hasNext),
    .stb(stb), .busy(busy), .done(done)
  );

  mrgen_seq #(.NUM_DIMMS(NUM_DIMMS)) uSeq (
    .clk(clk), .rstN(rstN), .stb(stb), .active(busy),
    .startTarget(targetDimm), .startLevel(levelMode),
    .dimmPresent(dimmPresent), .dimmDual(dimmDual),
    .curDimm(curDimm), .curRank(curRank), .curMr(curMr),
    .isTarget(isTarget), .levelQ(levelQ),
    .lastMr(lastMr), .moreRank(moreRank), .hasNext(hasNext)
  );

  mrgen_encode #(.NUM_DIMMS(NUM_DIMMS)) uEnc (
    .dimm(curDimm), .rank(curRank), .mrSel(curMr), .isTarget(isTarget),
    .level(levelQ), .dimmDual(dimmDual), .dimmX8(dimmX8), .tdqsEn(tdqsEn),
    .dimmsPerChan(dimmsPerChan), .freqCode(freqCode), .drvImp(drvImp),
    .srtEn(srtEn), .asrEn(asrEn), .cwlCode(cwlCode), .mirrorEn(mirrorEn),
    .cs(cmdCs), .bank(cmdBank), .addr(cmdAddr)
  );

  assign cmdValid = busy;

  AST_HOLD_CMD: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdAck) |=> (cmdValid && $stable(cmdAddr) && $stable(cmdBank) && $stable(cmdCs))); // R10
  AST_MR_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdAck && (!cmdCs[0] || !mirrorEn) && cmdBank == 3'd1)
      |=> (cmdValid && cmdBank == 3'd2 && $stable(cmdCs))); // R2

endmodule

// File: tb/sim_mrgen_top.sv
module sim_mrgen_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSCEN = 6;

  typedef struct packed {
    logic       lvl;
    logic [1:0] tgt;
    logic [3:0] pres;
    logic [3:0] dual;
    logic [3:0] x8;
    logic       tdqs;
    logic [2:0] dpc;
    logic [2:0] freq;
    logic [1:0] drv;
    logic       srt;
    logic       asr;
    logic [2:0] cwl;
    logic       mir;
    logic [4:0] cnt;
  } scen_t;

  localparam scen_t SCEN [NSCEN] = '{
    '{1'b1, 2'd0, 4'b0001, 4'b0001, 4'b0000, 1'b0, 3'd1, 3'd6, 2'd0, 1'b0, 1'b0, 3'd0, 1'b1, 5'd4},
    '{1'b1, 2'd1, 4'b0011, 4'b0011, 4'b0010, 1'b1, 3'd2, 3'd6, 2'd0, 1'b0, 1'b0, 3'd0, 1'b1, 5'd8},
    '{1'b1, 2'd1, 4'b0011, 4'b0001, 4'b0000, 1'b0, 3'd2, 3'd3, 2'd1, 1'b0, 1'b0, 3'd2, 1'b0, 5'd6},
    '{1'b0, 2'd2, 4'b1101, 4'b0100, 4'b0000, 1'b0, 3'd3, 3'd5, 2'd3, 1'b1, 1'b1, 3'd5, 1'b0, 5'd8},
    '{1'b0, 2'd0, 4'b1111, 4'b0000, 4'b1111, 1'b1, 3'd4, 3'd2, 2'd2, 1'b0, 1'b1, 3'd3, 1'b1, 5'd8},
    '{1'b1, 2'd2, 4'b0011, 4'b0000, 4'b0000, 1'b0, 3'd2, 3'd4, 2'd0, 1'b0, 1'b0, 3'd1, 1'b1, 5'd6}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0, levelMode = 1'b0, tdqsEn = 1'b0, srtEn = 1'b0, asrEn = 1'b0;
  logic mirrorEn = 1'b0, cmdAck = 1'b0;
  logic [1:0] targetDimm = '0, drvImp = '0;
  logic [3:0] dimmPresent = '0, dimmDual = '0, dimmX8 = '0;
  logic [2:0] dimmsPerChan = 3'd1, freqCode = '0, cwlCode = '0;
  logic cmdValid, busy, done;
  logic [2:0] cmdCs, cmdBank;
  logic [15:0] cmdAddr;

  int checks = 0;
  int errors = 0;

  logic [2:0]  expCs   [16];
  logic [2:0]  expBank [16];
  logic [15:0] expAddr [16];
  string       expTag  [16];
  int          expN;
  logic [2:0]  capCs   [16];
  logic [2:0]  capBank [16];
  logic [15:0] capAddr [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  mrgen_top u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .levelMode(levelMode),
    .targetDimm(targetDimm), .dimmPresent(dimmPresent), .dimmDual(dimmDual),
    .dimmX8(dimmX8), .tdqsEn(tdqsEn), .dimmsPerChan(dimmsPerChan),
    .freqCode(freqCode), .drvImp(drvImp), .srtEn(srtEn), .asrEn(asrEn),
    .cwlCode(cwlCode), .mirrorEn(mirrorEn), .cmdAck(cmdAck),
    .cmdValid(cmdValid), .cmdCs(cmdCs), .cmdBank(cmdBank), .cmdAddr(cmdAddr),
    .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] swapPairs(input logic [15:0] a);
    logic [15:0] b;
    b = a;
    b[3] = a[4]; b[4] = a[3];
    b[5] = a[6]; b[6] = a[5];
    b[7] = a[8]; b[8] = a[7];
    return b;
  endfunction

  task automatic addDimm(input scen_t s, input int d, input bit isT);
    int nr;
    logic [15:0] a, lowTier;
    bit dl, odd;
    dl = s.dual[d];
    nr = dl ? 2 : 1;
    lowTier = (s.freq < 5) ? 16'h0044 : 16'h0204;
    for (int r = 0; r < nr; r++) begin
      odd = (r == 1) && s.mir;
      a = 16'h0;
      if (s.lvl && isT) begin
        if (s.dpc == 1) a = (dl && r == 0) ? 16'h0 : 16'h0004;
        else a = (dl && r == 1) ? 16'h0 : ((s.freq == 6) ? 16'h0004 : 16'h0040);
        a = a | 16'h0080 | ((r == 1) ? 16'h1000 : 16'h0);
      end else if (s.lvl) begin
        a = (dl && r == 1) ? 16'h0 : lowTier;
      end else begin
        a = (s.dpc == 1 || s.dpc == 4) ? 16'h0004 : lowTier;
      end
      if (s.tdqs && s.x8[d]) a = a | 16'h0800;
      if (s.drv[1]) a = a | 16'h0020;
      if (s.drv[0]) a = a | 16'h0002;
      expCs[expN]   = 3'(d * 2 + r);
      expBank[expN] = odd ? 3'd2 : 3'd1;
      expAddr[expN] = odd ? swapPairs(a) : a;
      expTag[expN]  = (s.lvl && isT) ? "R6/R8 MR1" : "R7 MR1";
      expN++;
      a = {8'h0, s.srt, s.asr, s.cwl, 3'b000};
      if (!s.lvl && s.dpc != 1) a = a | ((s.freq == 6) ? 16'h0200 : 16'h0400);
      expCs[expN]   = 3'(d * 2 + r);
      expBank[expN] = odd ? 3'd1 : 3'd2;
      expAddr[expN] = odd ? swapPairs(a) : a;
      expTag[expN]  = "R9 MR2";
      expN++;
    end
  endtask

  task automatic buildModel(input scen_t s);
    expN = 0;
    addDimm(s, int'(s.tgt), 1'b1);
    for (int d = 0; d < 4; d++)
      if (s.pres[d] && d != int'(s.tgt)) addDimm(s, d, 1'b0);
  endtask

  task automatic runScen(input int k);
    scen_t s;
    int nObs;
    s = SCEN[k];
    buildModel(s);
    @(negedge clk);
    levelMode = s.lvl; targetDimm = s.tgt; dimmPresent = s.pres; dimmDual = s.dual;
    dimmX8 = s.x8; tdqsEn = s.tdqs; dimmsPerChan = s.dpc; freqCode = s.freq;
    drvImp = s.drv; srtEn = s.srt; asrEn = s.asr; cwlCode = s.cwl; mirrorEn = s.mir;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    chk(busy == 1'b1, "R11 busy after start", 32'(busy), 1);
    nObs = 0;
    for (int i = 0; i < expN; i++) begin
      for (int w = 0; w < 20 && !cmdValid; w++) @(negedge clk);
      if (!cmdValid) begin
        chk(1'b0, "R11 command missing", 0, 1);
        break;
      end
      nObs++;
      capCs[i] = cmdCs; capBank[i] = cmdBank; capAddr[i] = cmdAddr;
      chk(cmdCs == expCs[i], "R1/R3 chip select", 32'(cmdCs), 32'(expCs[i]));
      chk(cmdBank == expBank[i], "R2 bank", 32'(cmdBank), 32'(expBank[i]));
      chk(cmdAddr == expAddr[i], expTag[i], 32'(cmdAddr), 32'(expAddr[i]));
      if (i == 1) begin
        startReq = 1'b1;
        targetDimm = ~s.tgt;
        @(negedge clk);
        startReq = 1'b0;
        targetDimm = s.tgt;
        @(negedge clk);
        chk(cmdValid && cmdAddr == expAddr[i] && cmdCs == expCs[i] && cmdBank == expBank[i],
            "R10 hold without accept", 32'(cmdAddr), 32'(expAddr[i]));
        chk(busy == 1'b1, "R12 start while busy", 32'(busy), 1);
      end
      cmdAck = 1'b1;
      @(negedge clk);
      cmdAck = 1'b0;
    end
    chk(done == 1'b1 && busy == 1'b0, "R11 done after last accept", {30'h0, done, busy}, 32'h2);
    @(negedge clk);
    chk(done == 1'b0 && cmdValid == 1'b0, "R11 done single pulse", {30'h0, done, cmdValid}, 0);
    chk(nObs == int'(s.cnt), "R3 command count", 32'(nObs), 32'(s.cnt));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && cmdValid == 1'b0 && done == 1'b0, "R11 reset state",
        {29'h0, busy, cmdValid, done}, 0);
    cmdAck = 1'b1;
    @(negedge clk);
    cmdAck = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0 && cmdValid == 1'b0 && done == 1'b0, "R10 stray accept ignored",
        {29'h0, busy, cmdValid, done}, 0);

    for (int k = 0; k < NSCEN; k++) begin
      runScen(k);
      if (k == 0) begin
        chk(capAddr[0] == 16'h0080, "R6 one-DIMM rank0 off", 32'(capAddr[0]), 32'h0080);
        chk(capAddr[2] == 16'h1104, "R8 output off rank1 mirrored", 32'(capAddr[2]), 32'h1104);
        chk(capBank[2] == 3'd2 && capBank[3] == 3'd1, "R4 bank mirror",
            {capBank[2], capBank[3]}, 32'h11);
      end
      if (k == 1) begin
        chk(capAddr[0] == 16'h0884, "R5 TDQS x8", 32'(capAddr[0]), 32'h0884);
        chk(capAddr[4] == 16'h0204, "R8 non-target bits clear", 32'(capAddr[4]), 32'h0204);
      end
      if (k == 3) begin
        chk(capAddr[0] == 16'h0226, "R5 drive impedance", 32'(capAddr[0]), 32'h0226);
        chk(capAddr[1] == 16'h04E8 && capBank[1] == 3'd2, "R9 MR2 fields",
            32'(capAddr[1]), 32'h04E8);
      end
      if (k == 5) begin
        chk(capCs[0] == 3'd4, "R3 absent target first", 32'(capCs[0]), 4);
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule